// File: doc/BRIEF.md
# Quad-Group Shader Issue Scheduler

This block controls instruction issue for an in-order shader core that hides latency by interleaving many independent inputs. Inputs are placed in slots of four that share one instruction stream. Each slot is a "group". A group is fetched and decoded once per instruction. That instruction is then replayed over a datapath `LANES` inputs wide until all four inputs have executed it.

Every group is in one of four states: `G_FREE`, `G_READY`, `G_WALU` (parked on an operand still in flight from the ALU) or `G_WTEX` (blocked until its texture result returns). A group is granted only while a slot is free and the shared pool of physical registers can hold four times the temporaries it asks for. Its registers go back to the pool when it retires.

The central sequencer has three states:
- `S_PICK` → `S_FETCH` when some group is ready. The choice is round-robin, starting after the last group picked.
- `S_FETCH` → `S_PICK` when the fetched instruction collides with the group's scoreboard. The group is parked in `G_WALU`.
- `S_FETCH` → `S_ISSUE` when the instruction is clear of hazards.
- `S_ISSUE` → `S_ISSUE` while more beats remain.
- `S_ISSUE` → `S_PICK` on the final beat.

The group changes state on the final beat:
- `G_READY` → `G_WTEX` after a texture instruction.
- `G_READY` → `G_FREE` after the closing instruction.
- `G_WALU` → `G_READY` on any writeback to the group.
- `G_WTEX` → `G_READY` on texture completion.

The instruction store, the ALU and the texture unit are external. They answer through the fetch, writeback and texture ports.

Top module: `qsched_top`

## Requirements
- R1: After reset no fetch, issue, texture request or retire is signalled, and every slot is free.
- R2: An allocation request is granted in the same cycle only if a slot is free and four times `alloc_temps` does not exceed the free pool. The grant names the lowest-numbered free slot.
- R3: The registers held by a group are free again from the cycle after its retire pulse, and a request that fits may then be granted.
- R4: A group's instructions issue in program order. The first issued instruction sits at the allocation address, and each later one sits one address higher.
- R5: Each instruction issues in 4/`LANES` consecutive beats of the same group and address. `issue_lane` is the index of the first input in the beat: 0, `LANES`, and so on. `issue_last` marks the final beat.
- R6: An instruction does not issue while its source registers or its destination are pending in its group's scoreboard. An entry is set on the final beat of a non-texture, non-closing instruction and is cleared by `wb_valid` with that group and register. A parked group resumes after the writeback.
- R7: The final beat of a texture instruction (`fi_tex`=1) raises `tex_req` with the group id. That group then issues nothing until `tex_done` names it.
- R8: The final beat of the closing instruction (`fi_fin`=1) raises `retire_valid` with the group id. The group issues nothing more, and every granted group eventually retires.
- R9: When several groups are ready, the next one picked is the first ready group after the last picked group, in ascending id order with wrap-around.
- R10: The first beat of every instruction comes in the cycle right after `fetch_valid` presented the same group and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Request for a new group |
| alloc_temps | input | TW | Temporaries needed per input |
| alloc_pc | input | PCW | Start address of the group's program |
| alloc_grant | output | 1 | Request accepted this cycle |
| alloc_gid | output | GW | Slot given to the new group |
| fetch_valid | output | 1 | Instruction lookup in progress |
| fetch_gid | output | GW | Group being fetched |
| fetch_pc | output | PCW | Address being fetched |
| fi_tex | input | 1 | Fetched instruction is a texture access |
| fi_fin | input | 1 | Fetched instruction closes the program |
| fi_lat | input | 4 | ALU latency of the fetched instruction |
| fi_dst | input | RW | Destination register |
| fi_srca | input | RW | First source register |
| fi_srcb | input | RW | Second source register |
| issue_valid | output | 1 | An issue beat is presented |
| issue_gid | output | GW | Group of the beat |
| issue_lane | output | 2 | First input index covered by the beat |
| issue_pc | output | PCW | Address of the issued instruction |
| issue_tex | output | 1 | Issued instruction is a texture access |
| issue_lat | output | 4 | Latency of the issued instruction |
| issue_dst | output | RW | Destination of the issued instruction |
| issue_last | output | 1 | Final beat of the instruction |
| wb_valid | input | 1 | ALU result written back |
| wb_gid | input | GW | Group of the writeback |
| wb_reg | input | RW | Register written back |
| tex_req | output | 1 | Texture request sent |
| tex_gid | output | GW | Group of the texture request |
| tex_done | input | 1 | Texture result returned |
| tex_done_gid | input | GW | Group whose texture result returned |
| retire_valid | output | 1 | Group finished |
| retire_gid | output | GW | Group that finished |

## Verification
The bench builds the block with four groups, a 2-wide datapath, eight temporaries per input and a 48-register pool. This gives two-beat issue, and the pool runs dry after three groups of four temporaries while a slot is still free. Latencies up to 9 cycles and texture delays up to 10 cycles keep groups parked often enough for stale scoreboard entries, wake-ups and round-robin rotation to interact. Random programs run from random start addresses, so slot reuse after retirement is also reached.

// File: rtl/qsched_pkg.sv
package qsched_pkg;

    // Per-group occupancy state
    typedef enum logic [1:0] {
        G_FREE,
        G_READY,
        G_WALU,
        G_WTEX
    } gstate_e;

    // Central sequencer state
    typedef enum logic [1:0] {
        S_PICK,
        S_FETCH,
        S_ISSUE
    } fsm_e;

    // Instruction attributes kept while the beats replay
    typedef struct packed {
        logic       tex;
        logic       fin;
        logic [3:0] lat;
    } op_attr_t;

endpackage

// File: rtl/qsched_alloc.sv
module qsched_alloc #(
    parameter int NGROUPS = 4,
    parameter int NTEMP   = 8,
    parameter int POOL    = 48,
    parameter int THREADS = 4,
    localparam int GW = (NGROUPS > 1) ? $clog2(NGROUPS) : 1,
    localparam int TW = $clog2(NTEMP + 1),
    localparam int CW = $clog2(POOL + THREADS * NTEMP + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [TW-1:0]      temps,
    input  logic [NGROUPS-1:0] slot_busy,
    input  logic               ret_valid,
    input  logic [GW-1:0]      ret_gid,
    output logic               grant,
    output logic [GW-1:0]      gid
);

    logic [CW-1:0] free_q;
    logic [CW-1:0] held [NGROUPS];
    logic [CW-1:0] need;
    logic          found;

    assign need = CW'(temps) * CW'(THREADS);

    // Lowest-numbered free slot
    always_comb begin
        found = 1'b0;
        gid   = '0;
        for (int g = NGROUPS - 1; g >= 0; g--) begin
            if (!slot_busy[g]) begin
                found = 1'b1;
                gid   = GW'(g);
            end
        end
    end

    assign grant = req && found && (need <= free_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            free_q <= CW'(POOL);
            for (int g = 0; g < NGROUPS; g++) held[g] <= '0;
        end else begin
            free_q <= free_q - (grant ? need : '0) + (ret_valid ? held[ret_gid] : '0);
            if (grant) held[gid] <= need;
        end
    end

endmodule

// File: rtl/qsched_rr.sv
module qsched_rr #(
    parameter int N = 4,
    localparam int GW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  ready,
    input  logic [GW-1:0] last,
    output logic          any,
    output logic [GW-1:0] pick
);

    // Scan starts one past the last pick and wraps around
    always_comb begin
        any  = 1'b0;
        pick = last;
        for (int i = 1; i <= N; i++) begin
            if (!any && ready[(int'(last) + i) % N]) begin
                any  = 1'b1;
                pick = GW'((int'(last) + i) % N);
            end
        end
    end

endmodule

// File: rtl/qsched_sb.sv
module qsched_sb #(
    parameter int NGROUPS = 4,
    parameter int NTEMP   = 8,
    localparam int GW = (NGROUPS > 1) ? $clog2(NGROUPS) : 1,
    localparam int RW = (NTEMP > 1) ? $clog2(NTEMP) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_valid,
    input  logic [GW-1:0] set_gid,
    input  logic [RW-1:0] set_reg,
    input  logic          clr_valid,
    input  logic [GW-1:0] clr_gid,
    input  logic [RW-1:0] clr_reg,
    input  logic [GW-1:0] q_gid,
    input  logic [RW-1:0] q_a,
    input  logic [RW-1:0] q_b,
    input  logic [RW-1:0] q_d,
    output logic          hazard
);

    logic [NTEMP-1:0] busy [NGROUPS];
    logic [NTEMP-1:0] live;

    // A writeback landing this cycle already counts as resolved
    always_comb begin
        live = busy[q_gid];
        if (clr_valid && clr_gid == q_gid) live[clr_reg] = 1'b0;
        hazard = live[q_a] | live[q_b] | live[q_d];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < NGROUPS; g++) busy[g] <= '0;
        end else begin
            if (clr_valid) busy[clr_gid][clr_reg] <= 1'b0;
            if (set_valid) busy[set_gid][set_reg] <= 1'b1;
        end
    end

endmodule

// File: rtl/qsched_top.sv
module qsched_top
    import qsched_pkg::*;
#(
    parameter int NGROUPS = 4,
    parameter int LANES   = 2,
    parameter int NTEMP   = 8,
    parameter int POOL    = 48,
    parameter int PCW     = 8,
    localparam int GW    = (NGROUPS > 1) ? $clog2(NGROUPS) : 1,
    localparam int RW    = (NTEMP > 1) ? $clog2(NTEMP) : 1,
    localparam int TW    = $clog2(NTEMP + 1),
    localparam int BEATS = 4 / LANES,
    localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           alloc_req,
    input  logic [TW-1:0]  alloc_temps,
    input  logic [PCW-1:0] alloc_pc,
    output logic           alloc_grant,
    output logic [GW-1:0]  alloc_gid,
    output logic           fetch_valid,
    output logic [GW-1:0]  fetch_gid,
    output logic [PCW-1:0] fetch_pc,
    input  logic           fi_tex,
    input  logic           fi_fin,
    input  logic [3:0]     fi_lat,
    input  logic [RW-1:0]  fi_dst,
    input  logic [RW-1:0]  fi_srca,
    input  logic [RW-1:0]  fi_srcb,
    output logic           issue_valid,
    output logic [GW-1:0]  issue_gid,
    output logic [1:0]     issue_lane,
    output logic [PCW-1:0] issue_pc,
    output logic           issue_tex,
    output logic [3:0]     issue_lat,
    output logic [RW-1:0]  issue_dst,
    output logic           issue_last,
    input  logic           wb_valid,
    input  logic [GW-1:0]  wb_gid,
    input  logic [RW-1:0]  wb_reg,
    output logic           tex_req,
    output logic [GW-1:0]  tex_gid,
    input  logic           tex_done,
    input  logic [GW-1:0]  tex_done_gid,
    output logic           retire_valid,
    output logic [GW-1:0]  retire_gid
);

    fsm_e               st, st_nx;
    gstate_e            gst [NGROUPS];
    logic [PCW-1:0]     gpc [NGROUPS];
    logic [GW-1:0]      cur, last_pick;
    logic [BW-1:0]      beat;
    op_attr_t           op_q;
    logic [RW-1:0]      dst_q;
    logic [NGROUPS-1:0] ready_v, busy_v;
    logic               rr_any, hazard, beat_last, issue_done;
    logic [GW-1:0]      rr_pick;
    logic [1:0]         lane_idx;

    always_comb begin
        for (int g = 0; g < NGROUPS; g++) begin
            ready_v[g] = (gst[g] == G_READY);
            busy_v[g]  = (gst[g] != G_FREE);
        end
    end

    // Lane sequencing variant chosen by datapath width
    generate
        if (BEATS == 1) begin : g_wide
            assign beat_last = 1'b1;
            assign lane_idx  = 2'd0;
        end else begin : g_serial
            assign beat_last = (beat == BW'(BEATS - 1));
            assign lane_idx  = 2'(int'(beat) * LANES);
        end
    endgenerate

    qsched_alloc #(.NGROUPS(NGROUPS), .NTEMP(NTEMP), .POOL(POOL), .THREADS(4)) u_alloc (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (alloc_req),
        .temps     (alloc_temps),
        .slot_busy (busy_v),
        .ret_valid (retire_valid),
        .ret_gid   (retire_gid),
        .grant     (alloc_grant),
        .gid       (alloc_gid)
    );

    qsched_rr #(.N(NGROUPS)) u_rr (
        .ready (ready_v),
        .last  (last_pick),
        .any   (rr_any),
        .pick  (rr_pick)
    );

    qsched_sb #(.NGROUPS(NGROUPS), .NTEMP(NTEMP)) u_sb (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_valid (issue_done && !op_q.tex && !op_q.fin),
        .set_gid   (cur),
        .set_reg   (dst_q),
        .clr_valid (wb_valid),
        .clr_gid   (wb_gid),
        .clr_reg   (wb_reg),
        .q_gid     (cur),
        .q_a       (fi_srca),
        .q_b       (fi_srcb),
        .q_d       (fi_dst),
        .hazard    (hazard)
    );

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            S_PICK:  if (rr_any) st_nx = S_FETCH;
            S_FETCH: st_nx = hazard ? S_PICK : S_ISSUE;
            S_ISSUE: if (beat_last) st_nx = S_PICK;
            default: st_nx = S_PICK;
        endcase
    end

    // State register with the sequencer's working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= S_PICK;
            cur       <= '0;
            last_pick <= GW'(NGROUPS - 1);
            beat      <= '0;
            op_q      <= '0;
            dst_q     <= '0;
        end else begin
            st <= st_nx;
            if (st == S_PICK && rr_any) begin
                cur       <= rr_pick;
                last_pick <= rr_pick;
            end
            if (st == S_FETCH) begin
                op_q  <= '{tex: fi_tex, fin: fi_fin, lat: fi_lat};
                dst_q <= fi_dst;
                beat  <= '0;
            end else if (st == S_ISSUE && !beat_last) begin
                beat <= beat + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        fetch_valid  = (st == S_FETCH);
        fetch_gid    = cur;
        fetch_pc     = gpc[cur];
        issue_valid  = (st == S_ISSUE);
        issue_gid    = cur;
        issue_lane   = lane_idx;
        issue_pc     = gpc[cur];
        issue_tex    = op_q.tex;
        issue_lat    = op_q.lat;
        issue_dst    = dst_q;
        issue_last   = issue_valid && beat_last;
        issue_done   = issue_last;
        tex_req      = issue_done && op_q.tex;
        tex_gid      = cur;
        retire_valid = issue_done && op_q.fin;
        retire_gid   = cur;
    end

    // Group table
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < NGROUPS; g++) begin
                gst[g] <= G_FREE;
                gpc[g] <= '0;
            end
        end else begin
            for (int g = 0; g < NGROUPS; g++) begin
                if (alloc_grant && alloc_gid == GW'(g)) begin
                    gst[g] <= G_READY;
                    gpc[g] <= alloc_pc;
                end else begin
                    unique case (gst[g])
                        G_READY: begin
                            if (st == S_FETCH && cur == GW'(g) && hazard) begin
                                gst[g] <= G_WALU;
                            end else if (issue_done && cur == GW'(g)) begin
                                if (op_q.fin)      gst[g] <= G_FREE;
                                else if (op_q.tex) gst[g] <= G_WTEX;
                            end
                        end
                        G_WALU: if (wb_valid && wb_gid == GW'(g)) gst[g] <= G_READY;
                        G_WTEX: if (tex_done && tex_done_gid == GW'(g)) gst[g] <= G_READY;
                        default: ;
                    endcase
                    if (issue_done && cur == GW'(g)) gpc[g] <= gpc[g] + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/qsched_chk.sv
module qsched_chk #(
    parameter int NGROUPS = 4,
    parameter int LANES   = 2,
    parameter int PCW     = 8,
    localparam int GW = (NGROUPS > 1) ? $clog2(NGROUPS) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           alloc_req,
    input logic           alloc_grant,
    input logic           fetch_valid,
    input logic [GW-1:0]  fetch_gid,
    input logic [PCW-1:0] fetch_pc,
    input logic           issue_valid,
    input logic [GW-1:0]  issue_gid,
    input logic [1:0]     issue_lane,
    input logic [PCW-1:0] issue_pc,
    input logic           issue_tex,
    input logic           issue_last,
    input logic           tex_req,
    input logic [GW-1:0]  tex_gid,
    input logic           tex_done,
    input logic [GW-1:0]  tex_done_gid,
    input logic           retire_valid,
    input logic [GW-1:0]  retire_gid
);

    logic [NGROUPS-1:0] pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= '0;
        else begin
            if (tex_done) pend[tex_done_gid] <= 1'b0;
            if (tex_req)  pend[tex_gid]      <= 1'b1;
        end
    end

    a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_grant |-> alloc_req);

    a_r5_beats_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !issue_last) |=> (issue_valid && issue_gid == $past(issue_gid)
            && issue_pc == $past(issue_pc) && issue_lane == $past(issue_lane) + 2'(LANES)));

    a_r7_tex_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        tex_req |-> (issue_valid && issue_last && issue_tex && tex_gid == issue_gid));

    a_r7_blocked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !pend[issue_gid]);

    a_r8_retire_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |-> (issue_valid && issue_last && retire_gid == issue_gid));

    a_r10_fetch_before: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_lane == 2'd0) |-> ($past(fetch_valid)
            && $past(fetch_gid) == issue_gid && $past(fetch_pc) == issue_pc));

endmodule

bind qsched_top qsched_chk #(.NGROUPS(NGROUPS), .LANES(LANES), .PCW(PCW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_req    (alloc_req),
    .alloc_grant  (alloc_grant),
    .fetch_valid  (fetch_valid),
    .fetch_gid    (fetch_gid),
    .fetch_pc     (fetch_pc),
    .issue_valid  (issue_valid),
    .issue_gid    (issue_gid),
    .issue_lane   (issue_lane),
    .issue_pc     (issue_pc),
    .issue_tex    (issue_tex),
    .issue_last   (issue_last),
    .tex_req      (tex_req),
    .tex_gid      (tex_gid),
    .tex_done     (tex_done),
    .tex_done_gid (tex_done_gid),
    .retire_valid (retire_valid),
    .retire_gid   (retire_gid)
);

// File: tb/qsched_top_tb.sv
module qsched_top_tb;

    localparam int NG = 4;
    localparam int LN = 2;
    localparam int NT = 8;
    localparam int PL = 48;
    localparam int PW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic       alloc_req = 1'b0;
    logic [3:0] alloc_temps = '0;
    logic [PW-1:0] alloc_pc = '0;
    logic       alloc_grant;
    logic [1:0] alloc_gid;
    logic       fetch_valid;
    logic [1:0] fetch_gid;
    logic [PW-1:0] fetch_pc;
    logic       fi_tex, fi_fin;
    logic [3:0] fi_lat;
    logic [2:0] fi_dst, fi_srca, fi_srcb;
    logic       issue_valid, issue_tex, issue_last;
    logic [1:0] issue_gid, issue_lane;
    logic [PW-1:0] issue_pc;
    logic [3:0] issue_lat;
    logic [2:0] issue_dst;
    logic       wb_valid = 1'b0;
    logic [1:0] wb_gid = '0;
    logic [2:0] wb_reg = '0;
    logic       tex_req;
    logic [1:0] tex_gid;
    logic       tex_done = 1'b0;
    logic [1:0] tex_done_gid = '0;
    logic       retire_valid;
    logic [1:0] retire_gid;

    // Instruction store stub
    logic       p_tex [64];
    logic       p_fin [64];
    logic [3:0] p_lat [64];
    logic [2:0] p_dst [64];
    logic [2:0] p_a   [64];
    logic [2:0] p_b   [64];

    assign fi_tex  = p_tex[fetch_pc[5:0]];
    assign fi_fin  = p_fin[fetch_pc[5:0]];
    assign fi_lat  = p_lat[fetch_pc[5:0]];
    assign fi_dst  = p_dst[fetch_pc[5:0]];
    assign fi_srca = p_a[fetch_pc[5:0]];
    assign fi_srcb = p_b[fetch_pc[5:0]];

    qsched_top #(.NGROUPS(NG), .LANES(LN), .NTEMP(NT), .POOL(PL), .PCW(PW)) u_dut (.*);

    // Reference model state
    int  errs = 0, checks = 0;
    bit  alive [NG];
    int  held [NG];
    int  epc [NG];
    bit  busy [NG][NT];
    bit  tpend [NG];
    int  tdel [NG];
    int  pool_free = PL;
    bit  wq_v [32];
    int  wq_g [32], wq_r [32], wq_t [32];
    int  exp_lane = 0, cg = 0;
    bit  pf_v = 0;
    int  pf_g = 0, pf_pc = 0;
    bit  prev_ret = 0;
    int  ord [16];
    int  nord = 0;
    int  grants = 0, retires = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit any_alive();
        for (int g = 0; g < NG; g++) if (alive[g]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int free_slot();
        for (int g = 0; g < NG; g++) if (!alive[g]) return g;
        return -1;
    endfunction

    task automatic fill_indep();
        for (int i = 0; i < 64; i++) begin
            p_tex[i] = 0; p_fin[i] = (i % 8 == 7); p_lat[i] = 4'd1;
            p_dst[i] = 3'd0; p_a[i] = 3'd1; p_b[i] = 3'd2;
        end
    endtask

    task automatic fill_random();
        for (int i = 0; i < 64; i++) begin
            p_fin[i] = (i % 8 == 7);
            p_tex[i] = !p_fin[i] && ($urandom % 5 == 0);
            p_lat[i] = 4'($urandom_range(1, 9));
            p_dst[i] = 3'($urandom % 8); p_a[i] = 3'($urandom % 8); p_b[i] = 3'($urandom % 8);
        end
    endtask

    task automatic cycle(input bit areq, input int temps, input int apc);
        int slot, need, pc, g;
        bit eg, sent_wb, sent_tex, last;
        string tag;
        @(negedge clk);
        sent_wb = 0; wb_valid = 0;
        for (int i = 0; i < 32; i++) begin
            if (!sent_wb && wq_v[i] && wq_t[i] <= 0) begin
                sent_wb = 1; wb_valid = 1; wb_gid = 2'(wq_g[i]); wb_reg = 3'(wq_r[i]); wq_v[i] = 0;
            end
        end
        sent_tex = 0; tex_done = 0;
        for (int k = 0; k < NG; k++) begin
            if (!sent_tex && tpend[k] && tdel[k] <= 0) begin
                sent_tex = 1; tex_done = 1; tex_done_gid = 2'(k);
            end
        end
        alloc_req = areq; alloc_temps = 4'(temps); alloc_pc = PW'(apc);
        #1;
        slot = free_slot(); need = 4 * temps;
        eg = areq && slot >= 0 && need <= pool_free;
        tag = prev_ret ? "R3 grant after retire" : "R2 grant";
        if (areq) begin
            chk(tag, alloc_grant, eg);
            if (eg) chk("R2 lowest free slot", alloc_gid, slot);
        end
        last = 0;
        if (issue_valid) begin
            g = issue_gid; pc = issue_pc;
            if (exp_lane == 0) begin
                cg = g;
                chk("R8 issuing group is live", alive[g], 1);
                chk("R7 no issue while texture pending", tpend[g], 0);
                chk("R4 program order", pc, epc[g]);
                chk("R6 operands free at issue",
                    busy[g][p_a[pc[5:0]]] | busy[g][p_b[pc[5:0]]] | busy[g][p_dst[pc[5:0]]], 0);
                chk("R10 fetch precedes first beat", pf_v && pf_g == g && pf_pc == pc, 1);
                if (nord < 16) begin ord[nord] = g; nord++; end
            end else begin
                chk("R5 same group across beats", g, cg);
            end
            chk("R5 lane index", issue_lane, exp_lane);
            last = (exp_lane == 4 - LN);
            chk("R5 last beat flag", issue_last, last);
            if (last) begin
                chk("R7 texture request", tex_req, p_tex[pc[5:0]]);
                chk("R8 retire pulse", retire_valid, p_fin[pc[5:0]]);
            end
            exp_lane = last ? 0 : exp_lane + LN;
        end else begin
            if (tex_req || retire_valid) chk("R7 R8 no pulse without issue", 1, 0);
        end
        pf_v = fetch_valid; pf_g = fetch_gid; pf_pc = fetch_pc;
        // model update
        if (sent_wb) busy[wb_gid][wb_reg] = 0;
        if (sent_tex) tpend[tex_done_gid] = 0;
        for (int i = 0; i < 32; i++) if (wq_v[i]) wq_t[i]--;
        for (int k = 0; k < NG; k++) if (tpend[k]) tdel[k]--;
        prev_ret = 0;
        if (issue_valid && last) begin
            g = issue_gid; pc = issue_pc;
            epc[g]++;
            if (p_fin[pc[5:0]]) begin
                alive[g] = 0; pool_free += held[g]; prev_ret = 1; retires++;
            end else if (p_tex[pc[5:0]]) begin
                tpend[g] = 1; tdel[g] = $urandom_range(2, 10);
            end else begin
                busy[g][p_dst[pc[5:0]]] = 1;
                for (int i = 0; i < 32; i++) begin
                    if (!wq_v[i]) begin
                        wq_v[i] = 1; wq_g[i] = g; wq_r[i] = p_dst[pc[5:0]];
                        wq_t[i] = int'(p_lat[pc[5:0]]) - 1;
                        break;
                    end
                end
            end
        end
        if (eg) begin
            alive[slot] = 1; held[slot] = need; pool_free -= need; epc[slot] = apc; grants++;
        end
    endtask

    task automatic drain(input int cap);
        int n = 0;
        while (any_alive() && n < cap) begin cycle(0, 1, 0); n++; end
        chk("R8 every granted group retires", any_alive(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        bit got;
        void'($urandom(32'd2024));
        fill_indep();
        repeat (3) @(negedge clk);
        #1;
        chk("R1 no issue in reset", issue_valid, 0);
        chk("R1 no fetch in reset", fetch_valid, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 no retire after reset", retire_valid, 0);
        chk("R1 no texture request after reset", tex_req, 0);
        chk("R1 no issue after reset", issue_valid, 0);

        // Directed: rotation among four independent groups
        for (int k = 0; k < NG; k++) cycle(1, 2, 0);
        repeat (40) cycle(0, 1, 0);
        for (int i = 0; i < 8; i++) chk("R9 round-robin order", ord[i], i % NG);
        drain(500);

        // Directed: pool exhaustion with a free slot, then reuse after retire
        for (int k = 0; k < 3; k++) cycle(1, 4, 8 * k);
        chk("R2 pool empty after three large groups", pool_free, 0);
        cycle(1, 4, 24);
        got = 0;
        for (int n = 0; n < 300 && !got; n++) begin
            got = (free_slot() >= 0 && pool_free >= 16);
            cycle(1, 4, 32);
        end
        chk("R3 request granted once registers return", got, 1);
        drain(500);

        // Directed: all slots taken, pool not exhausted
        for (int k = 0; k < NG; k++) cycle(1, 1, 8 * k);
        cycle(1, 1, 40);
        drain(500);

        // Random programs, random allocations
        fill_random();
        for (int n = 0; n < 3000; n++)
            cycle(($urandom % 4) == 0, $urandom_range(1, 4), $urandom_range(0, 55));
        drain(3000);
        chk("R8 retire count matches grants", retires, grants);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule